// File: doc/BRIEF.md
# PATA Programmable Cycle Timing Generator

This block is the host-side pacing engine for a parallel ATA port. It turns one accepted access request into a complete bus cycle on the device cable. First it drives the address and chip-select lines for a single setup clock. It then asserts the read or write strobe for a programmed number of clocks and holds the bus for a programmed recovery time. When the recovery time ends it pulses `done`. Reads capture the device data bus on the clock edge where the strobe is released.

Strobe and recovery counts are stored per device: device 0 and device 1 each have their own 8-bit count. There are three timing sets:
- taskfile register accesses;
- accesses to the data port;
- multiword DMA bursts.

A byte-wide configuration write port loads any single count, or a per-device Ultra DMA enable flag. After reset the counts hold the slowest PIO timing, a 600 ns cycle, and the DMA counts hold the slowest multiword DMA timing. All counts are computed from nanosecond parameters and the clock period.

Top module: `pata_cycle_timer`

## Requirements
- R1: After reset the strobes and chip selects are high (inactive), DMA acknowledge is high, `req_ready` is 1 and `done` is 0. The counts come from the timing parameters: strobe code = ceil(active/clk)−1 and recovery code = ceil(cycle/clk)−ceil(active/clk)−1. The Ultra DMA enables are clear.
- R2: A configuration write with `cfg_sel` s and `cfg_dev` d changes only the count of set s for device d. The other device's count is unchanged. The `cfg_sel` codes are: 0 register strobe, 1 register recovery, 2 data strobe, 3 data recovery, 4 DMA strobe, 5 DMA recovery, 6 Ultra DMA enable (taken from `cfg_data[0]`). Code 7 is ignored.
- R3: A strobe code N holds the strobe low for N+1 clocks. Reads use `ata_dior_n` and writes use `ata_diow_n`, and the two are never low together.
- R4: A recovery code R leaves R+1 clocks with the strobe high after the strobe ends and before `done` rises. A code of 0 still gives one recovery clock.
- R5: Address and chip selects are driven for exactly one clock before the strobe falls. They stay stable until the recovery phase ends.
- R6: A command-block access at offset 0 (`req_ctl`=0, `req_addr`=0) uses the data set. Every other command-block offset, and any control-block access (`req_ctl`=1), uses the register set; `ata_cs0_n` goes low for command-block accesses and `ata_cs1_n` for control-block accesses. A DMA request (`req_dma`=1) uses the DMA set, drives `ata_dmack_n` low and keeps both chip selects high.
- R7: A DMA request to a device whose Ultra DMA enable is 1 is accepted but produces no strobe, and `done` is high in the first cycle after acceptance.
- R8: A request is taken only while `req_ready` is 1, which holds only when no access is in flight. Changes to the request inputs during an access do not alter that access's bus signals or timing.
- R9: `done` is a single-cycle pulse in the cycle following the last recovery clock, and `req_ready` is 1 in that cycle.
- R10: For a read, `rd_data` takes the value on `ata_dd_in` at the clock edge that ends the strobe.
- R11: For a write, `ata_dd_oe` is 1 and `ata_dd_out` equals the request's `req_wdata` from setup through recovery. For a read, `ata_dd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Which count (or Ultra DMA enable) to write |
| cfg_dev | input | 1 | Device whose field is written |
| cfg_data | input | 8 | New count value |
| req_valid | input | 1 | Access request |
| req_dma | input | 1 | 1 = DMA transfer, 0 = addressed PIO access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 1 | Target device, picks the timing field |
| req_ctl | input | 1 | 1 = control block, 0 = command block |
| req_addr | input | 3 | Register offset within the block |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Engine idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| ata_a | output | 3 | Device address lines |
| ata_cs0_n | output | 1 | Command block select, active low |
| ata_cs1_n | output | 1 | Control block select, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dmack_n | output | 1 | DMA acknowledge, active low |
| ata_dd_out | output | 16 | Data bus value driven by the host |
| ata_dd_oe | output | 1 | Host drives the data bus |
| ata_dd_in | input | 16 | Data bus value from the device |

## Verification
Three kinds of test run before any random traffic, and each separates a different fault:
- Default-count accesses to the data port, to a control-block register and to DMA. These show whether the reset values and the set selection (offset 0 against the rest, PIO against DMA) are right.
- Per-device writes followed by an access to the other device. These expose a write that spills into the wrong byte.
- A count of zero for both strobe and recovery. This separates an off-by-one in either counter from correct N+1 and R+1 lengths.

Random configuration writes and accesses then mix direction, device, block and offset, with the request inputs sometimes changed mid-access. Toggling the Ultra DMA enable splits the skipped DMA path from the normal one.

// File: rtl/pata_tmg_pkg.sv
package pata_tmg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } tmg_state_e;

  // Count table layout: strobe/recovery per set.
  localparam int NSETS    = 3;
  localparam int NSEL     = 2 * NSETS;
  localparam int SET_REG  = 0;
  localparam int SET_DATA = 1;
  localparam int SET_DMA  = 2;
  localparam int SEL_UDMA = 6;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Strobe code N gives N+1 clocks of active strobe.
  function automatic int strobe_code(input int act_ns, input int clk_ns);
    return ceil_div(act_ns, clk_ns) - 1;
  endfunction

  // Recovery code R fills the cycle: total = (N+1) + R + 1 clocks.
  function automatic int recov_code(input int cyc_ns, input int act_ns, input int clk_ns);
    return ceil_div(cyc_ns, clk_ns) - ceil_div(act_ns, clk_ns) - 1;
  endfunction

endpackage

// File: rtl/pata_tmg_regs.sv
module pata_tmg_regs
  import pata_tmg_pkg::*;
#(
  parameter int CW          = 8,
  parameter int CLK_NS      = 20,
  parameter int PIO_CYC_NS  = 600,
  parameter int PIO_ACT_NS  = 165,
  parameter int REG_ACT_NS  = 290,
  parameter int DMA_CYC_NS  = 480,
  parameter int DMA_ACT_NS  = 215
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [2:0]                      cfg_sel,
  input  logic                            cfg_dev,
  input  logic [CW-1:0]                   cfg_data,
  output logic [NSEL-1:0][1:0][CW-1:0]    tab_o,
  output logic [1:0]                      udma_en_o
);

  function automatic int reset_code(input int sel);
    case (sel)
      0:       return strobe_code(REG_ACT_NS, CLK_NS);
      1:       return recov_code(PIO_CYC_NS, REG_ACT_NS, CLK_NS);
      2:       return strobe_code(PIO_ACT_NS, CLK_NS);
      3:       return recov_code(PIO_CYC_NS, PIO_ACT_NS, CLK_NS);
      4:       return strobe_code(DMA_ACT_NS, CLK_NS);
      default: return recov_code(DMA_CYC_NS, DMA_ACT_NS, CLK_NS);
    endcase
  endfunction

  logic [CW-1:0] tab_q [NSEL][2];

  for (genvar s = 0; s < NSEL; s++) begin : g_sel
    for (genvar d = 0; d < 2; d++) begin : g_dev
      localparam logic [CW-1:0] RST_VAL = CW'(reset_code(s));
      logic hit;
      assign hit = cfg_we && (cfg_sel == 3'(s)) && (cfg_dev == 1'(d));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   tab_q[s][d] <= RST_VAL;
        else if (hit) tab_q[s][d] <= cfg_data;
      end
      assign tab_o[s][d] = tab_q[s][d];

      AST_OTHER_DEV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_dev != 1'(d)) |=> $stable(tab_o[s][d])); // R2
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_udma
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        udma_en_o[d] <= 1'b0;
      else if (cfg_we && cfg_sel == 3'(SEL_UDMA) && cfg_dev == 1'(d))
        udma_en_o[d] <= cfg_data[0];
    end

    AST_UDMA_OTHER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_dev != 1'(d)) |=> $stable(udma_en_o[d])); // R2
  end

endmodule

// File: rtl/pata_tmg_select.sv
module pata_tmg_select
  import pata_tmg_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [NSEL-1:0][1:0][CW-1:0] tab_i,
  input  logic [1:0]                   udma_en_i,
  input  logic                         req_dma,
  input  logic                         req_dev,
  input  logic                         req_ctl,
  input  logic [2:0]                   req_addr,
  output logic [CW-1:0]                stb_code,
  output logic [CW-1:0]                rcv_code,
  output logic                         skip
);

  int set_idx;

  always_comb begin
    if (req_dma)                           set_idx = SET_DMA;
    else if (!req_ctl && req_addr == 3'd0) set_idx = SET_DATA;
    else                                   set_idx = SET_REG;
    stb_code = tab_i[2*set_idx][req_dev];
    rcv_code = tab_i[2*set_idx+1][req_dev];
    skip     = req_dma && udma_en_i[req_dev];
  end

endmodule

// File: rtl/pata_tmg_seq.sv
module pata_tmg_seq
  import pata_tmg_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_dma,
  input  logic          req_write,
  input  logic          req_ctl,
  input  logic [2:0]    req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] stb_code,
  input  logic [CW-1:0] rcv_code,
  input  logic          skip,
  input  logic [DW-1:0] dd_in,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    ata_a,
  output logic          cs0_n,
  output logic          cs1_n,
  output logic          dior_n,
  output logic          diow_n,
  output logic          dmack_n,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe
);

  tmg_state_e    state;
  logic [CW-1:0] cnt, rcv_l;
  logic          wr_l, dma_l, ctl_l;
  logic [DW-1:0] wd_l;

  // Named events for the assertions.
  logic accept, busy, stb_last, rcv_last;
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = !req_ready;
  assign stb_last  = (state == ST_STROBE)  && (cnt == '0);
  assign rcv_last  = (state == ST_RECOVER) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rcv_l   <= '0;
      wr_l    <= 1'b0;
      dma_l   <= 1'b0;
      ctl_l   <= 1'b0;
      ata_a   <= '0;
      wd_l    <= '0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= (accept && skip) || rcv_last;
      case (state)
        ST_IDLE: if (accept && !skip) begin
          state <= ST_SETUP;
          cnt   <= stb_code;
          rcv_l <= rcv_code;
          wr_l  <= req_write;
          dma_l <= req_dma;
          ctl_l <= req_ctl;
          ata_a <= req_addr;
          wd_l  <= req_wdata;
        end
        ST_SETUP: state <= ST_STROBE;
        ST_STROBE: begin
          if (stb_last) begin
            state <= ST_RECOVER;
            cnt   <= rcv_l;
            if (!wr_l) rd_data <= dd_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RECOVER: begin
          if (rcv_last) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs0_n   = !(busy && !dma_l && !ctl_l);
  assign cs1_n   = !(busy && !dma_l && ctl_l);
  assign dmack_n = !(busy && dma_l);
  assign dior_n  = !((state == ST_STROBE) && !wr_l);
  assign diow_n  = !((state == ST_STROBE) && wr_l);
  assign dd_oe   = busy && wr_l;
  assign dd_out  = wd_l;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n)); // R3
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dior_n && diow_n) |-> ($stable(ata_a) && $stable({cs0_n, cs1_n, dmack_n}) && !$past(req_ready))); // R5
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ata_a) && $stable({cs0_n, cs1_n, dmack_n}) && $stable(dd_out))); // R5
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done); // R9
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dior_n && diow_n)); // R8

endmodule

// File: rtl/pata_cycle_timer.sv
module pata_cycle_timer
  import pata_tmg_pkg::*;
#(
  parameter int CW          = 8,
  parameter int DW          = 16,
  parameter int CLK_NS      = 20,
  parameter int PIO_CYC_NS  = 600,
  parameter int PIO_ACT_NS  = 165,
  parameter int REG_ACT_NS  = 290,
  parameter int DMA_CYC_NS  = 480,
  parameter int DMA_ACT_NS  = 215
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic          cfg_dev,
  input  logic [CW-1:0] cfg_data,
  input  logic          req_valid,
  input  logic          req_dma,
  input  logic          req_write,
  input  logic          req_dev,
  input  logic          req_ctl,
  input  logic [2:0]    req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    ata_a,
  output logic          ata_cs0_n,
  output logic          ata_cs1_n,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic          ata_dmack_n,
  output logic [DW-1:0] ata_dd_out,
  output logic          ata_dd_oe,
  input  logic [DW-1:0] ata_dd_in
);

  logic [NSEL-1:0][1:0][CW-1:0] tab;
  logic [1:0]                   udma_en;
  logic [CW-1:0]                stb_code, rcv_code;
  logic                         skip;

  pata_tmg_regs #(
    .CW(CW), .CLK_NS(CLK_NS), .PIO_CYC_NS(PIO_CYC_NS), .PIO_ACT_NS(PIO_ACT_NS),
    .REG_ACT_NS(REG_ACT_NS), .DMA_CYC_NS(DMA_CYC_NS), .DMA_ACT_NS(DMA_ACT_NS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_dev(cfg_dev), .cfg_data(cfg_data), .tab_o(tab), .udma_en_o(udma_en)
  );

  pata_tmg_select #(.CW(CW)) u_sel (
    .tab_i(tab), .udma_en_i(udma_en), .req_dma(req_dma), .req_dev(req_dev),
    .req_ctl(req_ctl), .req_addr(req_addr), .stb_code(stb_code),
    .rcv_code(rcv_code), .skip(skip)
  );

  pata_tmg_seq #(.CW(CW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dma(req_dma),
    .req_write(req_write), .req_ctl(req_ctl), .req_addr(req_addr),
    .req_wdata(req_wdata), .stb_code(stb_code), .rcv_code(rcv_code),
    .skip(skip), .dd_in(ata_dd_in), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .ata_a(ata_a), .cs0_n(ata_cs0_n), .cs1_n(ata_cs1_n),
    .dior_n(ata_dior_n), .diow_n(ata_diow_n), .dmack_n(ata_dmack_n),
    .dd_out(ata_dd_out), .dd_oe(ata_dd_oe)
  );

endmodule

// File: tb/pata_cycle_timer_tb.sv
module pata_cycle_timer_tb;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic        cfg_dev = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic        req_valid = 1'b0, req_dma = 1'b0, req_write = 1'b0;
  logic        req_dev = 1'b0, req_ctl = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic [2:0]  ata_a;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dmack_n, ata_dd_oe;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = '0;

  always #(CLK_NS/2) clk = ~clk;

  pata_cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_dev(cfg_dev),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_dma(req_dma),
    .req_write(req_write), .req_dev(req_dev), .req_ctl(req_ctl),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rd_data(rd_data), .ata_a(ata_a), .ata_cs0_n(ata_cs0_n),
    .ata_cs1_n(ata_cs1_n), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dmack_n(ata_dmack_n), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
    .ata_dd_in(ata_dd_in)
  );

  int tests = 0;
  int fails = 0;

  // Bench model: clocks of strobe and recovery per set/device.
  int  m_stb [3][2];
  int  m_rcv [3][2];
  bit  m_udma [2];

  function automatic int up(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cfg_write(input int sel, input bit dev, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_dev = dev; cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 6) begin
      if (sel % 2 == 0) m_stb[sel/2][dev] = val + 1;
      else              m_rcv[sel/2][dev] = val + 1;
    end else if (sel == 6) begin
      m_udma[dev] = val[0];
    end
  endtask

  task automatic access(input bit dma, input bit wr, input bit dev, input bit ctl,
                        input bit [2:0] addr, input bit [15:0] wd, input bit disturb);
    int set, pre, stb, rcv, bus_bad, rdy_bad, k;
    bit seen, skip, slow, other_low;
    bit [15:0] last_in;
    set  = dma ? 2 : ((!ctl && addr == 3'd0) ? 1 : 0);
    skip = dma && m_udma[dev];
    pre = 0; stb = 0; rcv = 0; bus_bad = 0; rdy_bad = 0; seen = 0; last_in = '0;
    @(negedge clk);
    req_valid = 1'b1; req_dma = dma; req_write = wr; req_dev = dev;
    req_ctl = ctl; req_addr = addr; req_wdata = wd;
    check(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
    @(negedge clk);
    if (disturb) begin
      req_addr = ~addr; req_write = ~wr; req_ctl = ~ctl; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    for (k = 0; k < 2000; k++) begin
      if (done) break;
      slow      = wr ? !ata_diow_n : !ata_dior_n;
      other_low = wr ? !ata_dior_n : !ata_diow_n;
      if (other_low) bus_bad++;
      if (req_ready) rdy_bad++;
      if (slow) begin stb++; seen = 1; end
      else if (seen) rcv++;
      else pre++;
      if (dma) begin
        if (!(ata_cs0_n && ata_cs1_n && !ata_dmack_n)) bus_bad++;
      end else begin
        if (ata_a != addr || !ata_dmack_n) bus_bad++;
        if (ctl && !(ata_cs0_n && !ata_cs1_n)) bus_bad++;
        if (!ctl && !(!ata_cs0_n && ata_cs1_n)) bus_bad++;
      end
      if (ata_dd_oe != wr) bus_bad++;
      if (wr && ata_dd_out != wd) bus_bad++;
      ata_dd_in = 16'($urandom);
      if (slow) last_in = ata_dd_in;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(k < 2000, "R9 done reached", k, 0);
    if (skip) begin
      check(k == 0, "R7 skipped DMA done at once", k, 0);
      check(stb == 0, "R7 skipped DMA no strobe", stb, 0);
    end else begin
      check(pre == 1, "R5 one setup clock", pre, 1);
      check(stb == m_stb[set][dev], "R3 strobe clocks", stb, m_stb[set][dev]);
      check(rcv == m_rcv[set][dev], "R4 recovery clocks", rcv, m_rcv[set][dev]);
      check(bus_bad == 0, "R6 R11 bus lines during access", bus_bad, 0);
      check(rdy_bad == 0, "R8 busy while in flight", rdy_bad, 0);
      if (!wr) check(rd_data == last_in, "R10 read capture", int'(rd_data), int'(last_in));
    end
    check(req_ready == 1'b1, "R9 ready with done", int'(req_ready), 1);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    #(200000 * CLK_NS);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A7A_0C5E));
    // Expected defaults: register set 290/600, data 165/600, DMA 215/480 ns.
    m_stb[0][0] = up(290, CLK_NS); m_rcv[0][0] = up(600, CLK_NS) - up(290, CLK_NS);
    m_stb[1][0] = up(165, CLK_NS); m_rcv[1][0] = up(600, CLK_NS) - up(165, CLK_NS);
    m_stb[2][0] = up(215, CLK_NS); m_rcv[2][0] = up(480, CLK_NS) - up(215, CLK_NS);
    for (int s = 0; s < 3; s++) begin
      m_stb[s][1] = m_stb[s][0];
      m_rcv[s][1] = m_rcv[s][0];
    end
    m_udma[0] = 0; m_udma[1] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ata_dior_n && ata_diow_n, "R1 strobes idle high", int'({ata_dior_n, ata_diow_n}), 3);
    check(ata_cs0_n && ata_cs1_n && ata_dmack_n, "R1 selects idle high",
          int'({ata_cs0_n, ata_cs1_n, ata_dmack_n}), 7);
    check(req_ready && !done, "R1 ready and no done", int'({req_ready, done}), 2);

    // R1 default counts, R6 set selection
    access(0, 0, 0, 0, 3'd0, 16'h0, 0);
    access(0, 0, 1, 1, 3'd6, 16'h0, 0);
    access(0, 1, 0, 0, 3'd7, 16'hBEEF, 0);
    access(1, 0, 1, 0, 3'd0, 16'h0, 0);

    // R2 per-device write leaves other device alone
    cfg_write(2, 1, 3);
    access(0, 0, 0, 0, 3'd0, 16'h0, 0);
    access(0, 0, 1, 0, 3'd0, 16'h0, 0);
    cfg_write(1, 0, 2);
    access(0, 1, 1, 0, 3'd3, 16'h1234, 0);

    // R3 R4 zero counts
    cfg_write(4, 0, 0);
    cfg_write(5, 0, 0);
    access(1, 1, 0, 0, 3'd0, 16'h5A5A, 0);
    access(1, 0, 0, 0, 3'd0, 16'h0, 0);

    // R7 Ultra DMA skip, per device; code 7 ignored
    cfg_write(6, 1, 1);
    cfg_write(7, 1, 0);
    access(1, 0, 1, 0, 3'd0, 16'h0, 0);
    access(1, 0, 0, 0, 3'd0, 16'h0, 0);
    access(0, 0, 1, 0, 3'd0, 16'h0, 0);
    cfg_write(6, 1, 0);
    access(1, 1, 1, 0, 3'd0, 16'hC0DE, 0);

    // R8 request inputs changed mid-access
    access(0, 0, 0, 1, 3'd6, 16'h0, 1);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      int sel;
      sel = $urandom_range(0, 7);
      cfg_write(sel, 1'($urandom), (sel >= 6) ? int'($urandom_range(0, 1)) : int'($urandom_range(0, 6)));
      access(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             3'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule